// File: doc/BRIEF.md
# Checkpoint Copy Conflict Tracker

This block protects the consistency of a memory region while a background checkpoint copy takes a snapshot of it. A start command carries a base address and a length. If the tracker is idle, it latches the range and enters a setup phase. In setup it holds a request to the cache to clean every dirty line of the range: the line is written back but stays resident. Any processor store aimed inside the range is stalled in the same cycle it is presented.

When the cache reports that cleaning has finished, the tracker moves to the copy phase and the store stall is lifted. From then on, every cache write-back whose address falls inside the range is vetoed, so that memory keeps the pre-checkpoint contents until the copy engine has read them. When the copy engine reports completion, the range is dropped and the tracker returns to idle.

A start command that arrives while a range is held is refused with a busy flag. Addresses are compared without wrap-around. A range that runs past the top of the address space covers only the addresses up to that top.

Top module: `ckpt_guard`

## Requirements
- R1: After reset the tracker is idle: `clean_req`, `cpu_stall`, `wb_veto` and `start_busy` are all low.
- R2: A `start_valid` seen while idle latches `start_base` and `start_len`. From the next cycle `clean_req` is high and `clean_base` and `clean_len` show the latched values.
- R3: A `start_valid` seen while a range is held raises `start_busy` in the same cycle and leaves the latched range unchanged.
- R4: An address hits when base <= addr < base + len. The sum is formed one bit wider than the address, so nothing wraps. A length of zero never hits.
- R5: In setup (`clean_req` high), `cpu_stall` equals `st_valid` AND hit(`st_addr`) in the same cycle. Stores outside the range are never stalled.
- R6: `clean_done` during setup ends setup at the next clock edge. After that edge `clean_req` is low and no store is stalled.
- R7: In the copy phase, `wb_veto` equals `wb_valid` AND hit(`wb_addr`) in the same cycle. In setup, write-backs are never vetoed.
- R8: `copy_done` during the copy phase returns the tracker to idle at the next clock edge. From then on nothing is stalled or vetoed, and a new start is accepted.
- R9: `copy_done` during setup and `clean_done` during the copy phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start a checkpoint of the given range |
| start_base | input | AW | Range base address |
| start_len | input | AW | Range length in address units |
| start_busy | output | 1 | Start refused because a range is held |
| st_valid | input | 1 | Processor store presented |
| st_addr | input | AW | Store address |
| cpu_stall | output | 1 | Hold the presented store |
| wb_valid | input | 1 | Cache write-back requested |
| wb_addr | input | AW | Write-back address |
| wb_veto | output | 1 | Refuse the presented write-back |
| clean_req | output | 1 | Ask the cache to clean the range (setup phase) |
| clean_base | output | AW | Range base for the clean |
| clean_len | output | AW | Range length for the clean |
| clean_done | input | 1 | Cache has finished cleaning |
| copy_done | input | 1 | Copy engine has finished |

## Verification
`cpu_stall`, `wb_veto` and `start_busy` are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. Phase changes caused by `start_valid`, `clean_done` and `copy_done` appear after exactly one rising edge. The bench therefore pulses those inputs for one cycle and checks the outputs in the cycle that follows. Every address of a 6-bit space is swept in each phase, for several ranges, and the expected hit is computed arithmetically in the bench.

// File: rtl/ckpt_guard.sv
module ckpt_guard #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic [AW-1:0] start_base,
  input  logic [AW-1:0] start_len,
  output logic          start_busy,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  output logic          cpu_stall,
  input  logic          wb_valid,
  input  logic [AW-1:0] wb_addr,
  output logic          wb_veto,
  output logic          clean_req,
  output logic [AW-1:0] clean_base,
  output logic [AW-1:0] clean_len,
  input  logic          clean_done,
  input  logic          copy_done
);

  typedef enum logic [1:0] {IDLE = 2'd0, SETUP = 2'd1, COPY = 2'd2} phase_t;

  phase_t        phase;
  logic [AW-1:0] base_q, len_q;
  logic [AW:0]   end_x;
  logic          st_hit, wb_hit, held;

  assign held  = (phase != IDLE);
  assign end_x = {1'b0, base_q} + {1'b0, len_q};

  function automatic logic in_range(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                    input logic [AW:0] e);
    return (a >= b) && ({1'b0, a} < e);
  endfunction

  assign st_hit = in_range(st_addr, base_q, end_x);
  assign wb_hit = in_range(wb_addr, base_q, end_x);

  assign start_busy = start_valid && held;
  assign cpu_stall  = st_valid && (phase == SETUP) && st_hit;
  assign wb_veto    = wb_valid && (phase == COPY) && wb_hit;
  assign clean_req  = (phase == SETUP);
  assign clean_base = base_q;
  assign clean_len  = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= IDLE;
      base_q <= '0;
      len_q  <= '0;
    end else begin
      unique case (phase)
        IDLE:  if (start_valid) begin
                 base_q <= start_base;
                 len_q  <= start_len;
                 phase  <= SETUP;
               end
        SETUP: if (clean_done) phase <= COPY;
        COPY:  if (copy_done) phase <= IDLE;
        default: phase <= IDLE;
      endcase
    end
  end

  a_r2_start_cleans: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !held) |=> (clean_req && clean_base == $past(start_base)
                                && clean_len == $past(start_len)));
  a_r3_range_kept: assert property (@(posedge clk) disable iff (!rst_n)
    start_busy |=> ($stable(clean_base) && $stable(clean_len)));
  a_r5_stall_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (st_valid && clean_req));
  a_r7_veto_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_veto |-> (wb_valid && !clean_req && held));
  a_r6_setup_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_req && clean_done) |=> (!clean_req && !cpu_stall));
  a_r8_copy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == COPY && copy_done) |=> (!wb_veto && !cpu_stall && !held));
  a_r9_early_copy_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_req && copy_done && !clean_done) |=> clean_req);

endmodule

// File: tb/ckpt_guard_test.sv
module ckpt_guard_test;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, st_valid = 0, wb_valid = 0, clean_done = 0, copy_done = 0;
  logic [AW-1:0] start_base = 0, start_len = 0, st_addr = 0, wb_addr = 0;
  logic start_busy, cpu_stall, wb_veto, clean_req;
  logic [AW-1:0] clean_base, clean_len;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ckpt_guard #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_base(start_base),
    .start_len(start_len), .start_busy(start_busy), .st_valid(st_valid), .st_addr(st_addr),
    .cpu_stall(cpu_stall), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_veto(wb_veto),
    .clean_req(clean_req), .clean_base(clean_base), .clean_len(clean_len),
    .clean_done(clean_done), .copy_done(copy_done));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  function automatic int hit(int a, int b, int l);
    return (a >= b && a < b + l) ? 1 : 0;
  endfunction

  task automatic sweep(input int b, input int l, input int ph);
    for (int a = 0; a < N; a++) begin
      st_valid = 1; wb_valid = 1; st_addr = a[AW-1:0]; wb_addr = a[AW-1:0];
      #1;
      chk(ph == 1 ? "R5 stall" : "R8 stall", cpu_stall, ph == 1 ? hit(a, b, l) : 0);
      chk(ph == 2 ? "R7 veto" : "R4 veto", wb_veto, ph == 2 ? hit(a, b, l) : 0);
      step();
    end
    st_valid = 0; wb_valid = 1; wb_addr = b[AW-1:0]; #1;
    chk("R5 no store no stall", cpu_stall, 0);
    step();
    wb_valid = 0; st_valid = 1; st_addr = b[AW-1:0]; #1;
    chk("R7 no wb no veto", wb_veto, 0);
    step(); st_valid = 0;
  endtask

  task automatic run_case(input int b, input int l);
    start_valid = 1; start_base = b[AW-1:0]; start_len = l[AW-1:0]; #1;
    chk("R3 busy idle", start_busy, 0);
    step(); start_valid = 0; #1;
    chk("R2 clean_req", clean_req, 1);
    chk("R2 clean_base", clean_base, b);
    chk("R2 clean_len", clean_len, l);
    step();
    sweep(b, l, 1);
    start_valid = 1; start_base = 6'd1; start_len = 6'd2; #1;
    chk("R3 busy setup", start_busy, 1);
    step(); start_valid = 0; #1;
    chk("R3 base kept", clean_base, b);
    chk("R3 len kept", clean_len, l);
    copy_done = 1; step(); copy_done = 0; #1;
    chk("R9 copy_done in setup", clean_req, 1);
    clean_done = 1; step(); clean_done = 0; #1;
    chk("R6 clean_req low", clean_req, 0);
    step();
    sweep(b, l, 2);
    start_valid = 1; #1;
    chk("R3 busy copy", start_busy, 1);
    step(); start_valid = 0;
    clean_done = 1; step(); clean_done = 0;
    wb_valid = 1; wb_addr = b[AW-1:0]; #1;
    chk("R9 clean_done in copy", wb_veto, hit(b, b, l));
    step(); wb_valid = 0;
    copy_done = 1; step(); copy_done = 0; #1;
    chk("R8 idle clean_req", clean_req, 0);
    sweep(b, l, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    #1;
    chk("R1 clean_req", clean_req, 0);
    chk("R1 stall", cpu_stall, 0);
    chk("R1 veto", wb_veto, 0);
    chk("R1 busy", start_busy, 0);
    step(); rst_n = 1; step();
    run_case(8, 5);
    run_case(0, 1);
    run_case(60, 10);
    run_case(20, 0);
    run_case(0, 63);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule